// File: doc/BRIEF.md
# Peripheral Chip-Select Timing Generator

This block produces the control strobes for a single external memory bank on a synchronous bus. A one-cycle start pulse from the bus master opens an access. The block then drives an active-low chip select, an active-low output enable for reads, a set of active-low per-byte write enables for writes, and an active-high transfer acknowledge back to the master. The configuration is latched when the start pulse is taken. It consists of the direction, a two-bit address-to-select setup code, a relaxed-timing flag, an early-negation flag, an external-acknowledge select and an internal wait count.

Cycle 0 is the clock cycle in which `start_i` is high while the block is idle. Cycle 1, the next cycle, is the first access cycle, and the address is valid from that cycle on. A register clocked on the falling edge of the clock produces the half-cycle delay of chip select. Relaxed timing has two effects: it inserts a setup cycle before any strobe, and it makes every access last at least three cycles. A relaxed write with early negation releases its strobes one cycle sooner.

Top module: `cs_timing_gen`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `cs_no`, `oe_no` and every bit of `we_no` are 1 and `ta_o` is 0 until a start is taken.
- R2: With relaxed timing clear and setup code 2'b00, 2'b01 or 2'b10 (01 and 10 behave as 00), chip select and the direction strobe are low for the whole of cycle 1.
- R3: With setup code 2'b11, chip select stays high in the first half of the first strobe cycle and goes low at that cycle's falling edge. The other strobes are not delayed.
- R4: With relaxed timing set, cycle 1 has no strobe asserted. The strobes begin in cycle 2, and with setup code 2'b11 chip select begins half a cycle later still.
- R5: With the internal acknowledge selected and wait count N, `ta_o` is high for exactly one cycle: cycle 1+N without relaxed timing, and cycle 3+N with relaxed timing.
- R6: With the external acknowledge selected, `ta_o` follows `ext_ack_i` from cycle 1 without relaxed timing, and from cycle 3 with relaxed timing. An `ext_ack_i` pulse in an earlier cycle is ignored.
- R7: Outside early negation, every strobe stays asserted through the acknowledge cycle and is negated in the cycle after it.
- R8: On a relaxed write with early negation set, the write enables are high in the acknowledge cycle. Chip select is also high in that cycle unless the setup code is 2'b11. Early negation has no effect on reads or without relaxed timing.
- R9: `oe_no` goes low only on reads (`rd_i`=1). `we_no[i]` goes low only on writes and only when `be_i[i]`=1 at start.
- R10: A start pulse during an access is ignored, and the configuration latched at start is kept when the inputs change during the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer start pulse |
| rd_i | input | 1 | 1 = read, 0 = write |
| setup_i | input | 2 | Address-to-select setup code (2'b11 = half-cycle delay) |
| relax_i | input | 1 | Relaxed timing enable |
| early_neg_i | input | 1 | Early strobe negation on relaxed writes |
| ext_sel_i | input | 1 | 1 = acknowledge comes from ext_ack_i |
| wait_i | input | WAIT_W | Internal wait-state count |
| be_i | input | NUM_BE | Byte enables for writes |
| ext_ack_i | input | 1 | External device acknowledge, active high |
| cs_no | output | 1 | Chip select, active low |
| oe_no | output | 1 | Output enable, active low |
| we_no | output | NUM_BE | Write/byte enables, active low |
| ta_o | output | 1 | Transfer acknowledge to master |

## Verification
The bench runs reads and writes with every setup code, with relaxed timing on and off, and with wait counts of 0, 1, 2, 3 and 15. These runs separate the setup-cycle shift, the half-cycle chip select and the wait-count placement of the acknowledge. Relaxed writes with early negation use setup codes 00 and 11, so that only the write enables, or the write enables together with chip select, are released early. Matching reads and non-relaxed writes show that the flag has no effect there. For the external acknowledge, the bench uses a level from cycle 1, a rejected cycle-2 pulse followed by a later level, and a level that is held back until cycle 3. For R10, a start pulse and changed configuration inputs arrive during an access.

// File: rtl/cs_timing_pkg.sv
`timescale 1ns/1ps
package cs_timing_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } phase_e;

  typedef struct packed {
    logic       rd;
    logic [1:0] setup;
    logic       relax;
    logic       early;
    logic       ext_sel;
  } acc_cfg_t;

  localparam logic [1:0] SETUP_HALF = 2'b11;
endpackage

// File: rtl/cs_seq.sv
`timescale 1ns/1ps
module cs_seq
  import cs_timing_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int NUM_BE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  acc_cfg_t          cfg_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [NUM_BE-1:0] be_i,
  input  logic              ext_ack_i,
  output phase_e            phase_o,
  output acc_cfg_t          cfg_o,
  output logic [NUM_BE-1:0] be_o,
  output logic              ta_o
);
  localparam int CNT_W = WAIT_W + 1;

  phase_e     phase_q;
  acc_cfg_t   cfg_q;
  logic [NUM_BE-1:0] be_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  load_cnt;
  logic              ta;

  // relaxed mode adds one mandatory cycle before acknowledge may be taken
  assign load_cnt = (cfg_i.ext_sel ? '0 : {1'b0, wait_i}) + CNT_W'(cfg_i.relax);

  assign ta = (phase_q == ST_STROBE) && (cnt_q == '0) && (cfg_q.ext_sel ? ext_ack_i : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      cfg_q   <= '0;
      be_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        ST_IDLE: begin
          if (start_i) begin
            cfg_q   <= cfg_i;
            be_q    <= be_i;
            cnt_q   <= load_cnt;
            phase_q <= cfg_i.relax ? ST_SETUP : ST_STROBE;
          end
        end
        ST_SETUP: phase_q <= ST_STROBE;
        ST_STROBE: begin
          if (ta)                 phase_q <= ST_IDLE;
          else if (cnt_q != '0)   cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cfg_o   = cfg_q;
  assign be_o    = be_q;
  assign ta_o    = ta;
endmodule

// File: rtl/cs_half_reg.sv
`timescale 1ns/1ps
module cs_half_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cs_strobe_dec.sv
`timescale 1ns/1ps
module cs_strobe_dec
  import cs_timing_pkg::*;
#(
  parameter int NUM_BE = 4
) (
  input  logic              active_i,
  input  logic              half_i,
  input  logic              rd_i,
  input  logic [1:0]        setup_i,
  input  logic              relax_i,
  input  logic              early_i,
  input  logic [NUM_BE-1:0] be_i,
  input  logic              ta_i,
  output logic              cs_no,
  output logic              oe_no,
  output logic [NUM_BE-1:0] we_no
);
  logic early_now;
  logic half_mode;
  logic cs_on;

  assign early_now = relax_i & early_i & ~rd_i & ta_i;
  assign half_mode = (setup_i == SETUP_HALF);
  // half-delayed select is never released early
  assign cs_on     = active_i & (half_mode ? half_i : ~early_now);

  assign cs_no = ~cs_on;
  assign oe_no = ~(active_i & rd_i);

  for (genvar i = 0; i < NUM_BE; i++) begin : g_we
    assign we_no[i] = ~(active_i & ~rd_i & be_i[i] & ~early_now);
  end
endmodule

// File: rtl/cs_timing_gen.sv
`timescale 1ns/1ps
module cs_timing_gen
  import cs_timing_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int NUM_BE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [1:0]        setup_i,
  input  logic              relax_i,
  input  logic              early_neg_i,
  input  logic              ext_sel_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [NUM_BE-1:0] be_i,
  input  logic              ext_ack_i,
  output logic              cs_no,
  output logic              oe_no,
  output logic [NUM_BE-1:0] we_no,
  output logic              ta_o
);
  acc_cfg_t          cfg_in;
  acc_cfg_t          cfg_w;
  phase_e            phase_w;
  logic [NUM_BE-1:0] be_w;
  logic              ta_w;
  logic              active_w;
  logic              half_w;

  assign cfg_in = '{rd: rd_i, setup: setup_i, relax: relax_i,
                    early: early_neg_i, ext_sel: ext_sel_i};

  cs_seq #(.WAIT_W(WAIT_W), .NUM_BE(NUM_BE)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cfg_i     (cfg_in),
    .wait_i    (wait_i),
    .be_i      (be_i),
    .ext_ack_i (ext_ack_i),
    .phase_o   (phase_w),
    .cfg_o     (cfg_w),
    .be_o      (be_w),
    .ta_o      (ta_w)
  );

  assign active_w = (phase_w == ST_STROBE);

  cs_half_reg u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (active_w),
    .q_o    (half_w)
  );

  cs_strobe_dec #(.NUM_BE(NUM_BE)) u_dec (
    .active_i (active_w),
    .half_i   (half_w),
    .rd_i     (cfg_w.rd),
    .setup_i  (cfg_w.setup),
    .relax_i  (cfg_w.relax),
    .early_i  (cfg_w.early),
    .be_i     (be_w),
    .ta_i     (ta_w),
    .cs_no    (cs_no),
    .oe_no    (oe_no),
    .we_no    (we_no)
  );

  assign ta_o = ta_w;
endmodule

// File: rtl/cs_timing_chk.sv
`timescale 1ns/1ps
module cs_timing_chk
  import cs_timing_pkg::*;
#(
  parameter int NUM_BE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ext_ack_i,
  input logic              cs_no,
  input logic              oe_no,
  input logic [NUM_BE-1:0] we_no,
  input logic              ta_o,
  input phase_e            phase,
  input acc_cfg_t          cfg_q
);
  // R5
  ta_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !ta_o);

  // R7
  release_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> (cs_no && oe_no && (&we_no)));

  // R4
  setup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_SETUP) |-> (cs_no && oe_no && (&we_no) && !ta_o));

  // R6
  ext_ack_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ta_o && cfg_q.ext_sel) |-> ext_ack_i);

  // R9
  dir_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !(&we_no)));

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != ST_IDLE && start_i) |=> $stable(cfg_q));
endmodule

bind cs_timing_gen cs_timing_chk #(.NUM_BE(NUM_BE)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ext_ack_i (ext_ack_i),
  .cs_no     (cs_no),
  .oe_no     (oe_no),
  .we_no     (we_no),
  .ta_o      (ta_o),
  .phase     (phase_w),
  .cfg_q     (cfg_w)
);

// File: tb/cs_timing_gen_tb_top.sv
`timescale 1ns/1ps
module cs_timing_gen_tb_top;
  localparam int WAIT_W = 4;
  localparam int NUM_BE = 4;

  typedef struct {
    int         cyc;
    logic       cs_a;
    logic       cs_b;
    logic       oe;
    logic [3:0] we;
    logic       ta;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, rd_i = 1'b0, relax_i = 1'b0, early_neg_i = 1'b0;
  logic ext_sel_i = 1'b0, ext_ack_i = 1'b0;
  logic [1:0] setup_i = 2'b00;
  logic [WAIT_W-1:0] wait_i = '0;
  logic [NUM_BE-1:0] be_i = '0;
  logic cs_no, oe_no, ta_o;
  logic [NUM_BE-1:0] we_no;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  cs_timing_gen #(.WAIT_W(WAIT_W), .NUM_BE(NUM_BE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rd_i(rd_i),
    .setup_i(setup_i), .relax_i(relax_i), .early_neg_i(early_neg_i),
    .ext_sel_i(ext_sel_i), .wait_i(wait_i), .be_i(be_i), .ext_ack_i(ext_ack_i),
    .cs_no(cs_no), .oe_no(oe_no), .we_no(we_no), .ta_o(ta_o)
  );

  task automatic cmp(input exp_t e, input logic cs_exp, input string half);
    checks++;
    if (cs_no !== cs_exp || oe_no !== e.oe || we_no !== e.we || ta_o !== e.ta) begin
      fails++;
      $display("FAIL %s cyc+%0d %s: act cs=%b oe=%b we=%b ta=%b exp cs=%b oe=%b we=%b ta=%b",
               e.tag, e.cyc, half, cs_no, oe_no, we_no, ta_o, cs_exp, e.oe, e.we, e.ta);
    end
  endtask

  // monitor: pops expected items as their cycle comes up
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1.5;
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        exp_t e;
        e = exp_q[0];
        cmp(e, e.cs_a, "first half");
        #2;
        cmp(e, e.cs_b, "second half");
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic access(input logic rd, input logic [1:0] setup, input logic relax,
                        input logic early, input logic ext, input int wt,
                        input logic [3:0] be, input int p1, input int p2,
                        input int stray, input string tag);
    int s, mn, t, base;
    s  = relax ? 2 : 1;
    mn = relax ? 3 : 1;
    if (!ext) t = mn + wt;
    else if (p1 >= mn && p1 > 0) t = p1;
    else t = (p2 > mn) ? p2 : mn;
    @(posedge clk); #0.5;
    base = cyc;
    start_i = 1'b1; rd_i = rd; setup_i = setup; relax_i = relax;
    early_neg_i = early; ext_sel_i = ext; wait_i = WAIT_W'(wt); be_i = be;
    ext_ack_i = 1'b0;
    for (int c = 1; c <= t + 2; c++) begin
      exp_t e;
      logic strobe, early_c, hm;
      strobe  = (c >= s) && (c <= t);
      early_c = relax & early & ~rd & (c == t);
      hm      = (setup == 2'b11);
      e.cyc  = base + c;
      e.oe   = ~(strobe & rd);
      for (int i = 0; i < 4; i++) e.we[i] = ~(strobe & ~rd & be[i] & ~early_c);
      e.ta   = (c == t);
      e.cs_a = ~(strobe & (hm ? (c > s) : ~early_c));
      e.cs_b = ~(strobe & (hm ? 1'b1 : ~early_c));
      e.tag  = tag;
      exp_q.push_back(e);
    end
    for (int c = 1; c <= t + 2; c++) begin
      @(posedge clk); #0.5;
      start_i = (c == stray) && (c <= t);
      // scrambled config while busy must not matter (R10)
      rd_i = ~rd; setup_i = ~setup; relax_i = ~relax; early_neg_i = ~early;
      ext_sel_i = ~ext; wait_i = ~WAIT_W'(wt); be_i = ~be;
      ext_ack_i = ext && (c <= t) && ((c == p1) || (p2 > 0 && c >= p2));
    end
    start_i = 1'b0; ext_ack_i = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    checks++;
    if (cs_no !== 1'b1 || oe_no !== 1'b1 || we_no !== 4'hF || ta_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: act cs=%b oe=%b we=%b ta=%b exp 1 1 1111 0", cs_no, oe_no, we_no, ta_o);
    end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #1.5;
    checks++;
    if (cs_no !== 1'b1 || oe_no !== 1'b1 || we_no !== 4'hF || ta_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: act cs=%b oe=%b we=%b ta=%b exp 1 1 1111 0", cs_no, oe_no, we_no, ta_o);
    end
    //     rd   setup  rlx  ern  ext  wt  be     p1 p2 stray
    access(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 0, 4'hF, 0, 0, 0, "R2 R5 R7 read w0");
    access(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 2, 4'hF, 0, 0, 0, "R3 R5 read half w2");
    access(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1, 4'h5, 0, 0, 0, "R9 R2 write be0101");
    access(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 0, 4'hF, 0, 0, 0, "R4 R5 relaxed write");
    access(1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1, 4'hF, 0, 0, 0, "R4 R3 relaxed half read");
    access(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1, 4'hF, 0, 0, 0, "R8 early write s00");
    access(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 0, 4'hA, 0, 0, 0, "R8 early write s11");
    access(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1, 4'hF, 0, 0, 0, "R8 R7 early ignored unrelaxed");
    access(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1, 4'hF, 0, 0, 0, "R8 R9 early ignored read");
    access(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 0, 4'hF, 0, 1, 0, "R6 ext zero wait");
    access(1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 0, 4'hF, 2, 5, 0, "R6 ext early pulse rejected");
    access(1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 0, 4'hF, 0, 1, 0, "R6 ext relaxed min three");
    access(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 0, 4'h3, 0, 0, 0, "R2 R4 setup01 as 00");
    access(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 2, 4'hF, 0, 0, 0, "R2 setup10 as 00");
    access(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 3, 4'hF, 0, 0, 2, "R10 stray start");
    access(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 15, 4'hC, 0, 0, 0, "R5 max wait");
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 scoreboard leftover: act %0d exp 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule